// File: doc/BRIEF.md
# Four-Lane Stepped CORDIC Iteration Unit

This block is a shared CORDIC arithmetic unit that serves four 16-bit SIMD lanes. It does not run an angle conversion to completion. Each run command advances every lane by exactly one micro-iteration, which is one arithmetic shift followed by one add or subtract on x, y and the angle z. Software issues as many run commands as it needs precision, usually sixteen for a 16-bit result, and feeds each result word back as the next operand.

Each lane keeps its own settings between commands: the mode (rotation or vectoring), the coordinate system (circular, linear or hyperbolic), the current iteration index and the running angle. A configure command loads one byte per lane. The four lanes can therefore run four unrelated conversions at once, for example a sine/cosine, a division, a logarithm and a magnitude. Gain compensation is left to software, and so is keeping inputs inside the convergence range.

Angles and linear-mode quotients use a signed format with 13 fraction bits, so the value 1.0 is 8192.

Top module: `cordic_simd_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `out_xy` and `out_z` are all zero. Every lane starts at iteration index 31 with a fresh angle, so a run before any configure returns the lane's x, y and `run_z` unchanged.
- R2: A configure command loads byte k of `cfg_word` (bits 8k+7..8k) into lane k. Bit 7 is the mode (0 rotation, 1 vectoring). Bits 6..5 are the system (00 circular, 01 linear, 10 hyperbolic; 11 acts as circular). Bits 4..0 are the starting iteration index.
- R3: A run command completes one iteration on all lanes. The result appears in the next cycle with `out_valid` high. Lane k's x is in bits 32k+31..32k+16 of `out_xy`, its y is in bits 32k+15..32k, and its angle is in bits 16k+15..16k of `out_z`. Operands use the same positions in `run_xy` and `run_z`.
- R4: In iteration n the direction d is +1 when z ≥ 0 (rotation mode) or when y < 0 (vectoring mode), and −1 otherwise. The updates are y' = y + d·(x>>>n) and z' = z − d·e(n). The x update is x − d·(y>>>n) for circular, x unchanged for linear, and x + d·(y>>>n) for hyperbolic. All arithmetic is 16-bit two's complement with wrap-around.
- R5: e(n) is round(8192·atan 2^−n) for circular n < 8 and round(8192·atanh 2^−n) for hyperbolic n < 6. In every other case, including all linear iterations, it is 8192 >> n.
- R6: The first run after a configure takes the lane's angle from `run_z`. Later runs use the angle the lane kept internally and ignore `run_z`.
- R7: Every run advances each lane's index by one, independently of the other lanes.
- R8: A hyperbolic lane configured with index 0 starts at 1. Iterations 4 and 13 are each executed twice before the index moves on.
- R9: At index 31 a run returns x, y and the angle source unchanged, and the index stays at 31.
- R10: A configure and a run in the same cycle apply only the configure. The run is dropped and `out_valid` stays low in the next cycle.
- R11: Linear vectoring that starts with z = 0 and |y/x| < 2 leaves about 8192·y/x in z after 16 iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configure command strobe |
| cfg_word | input | 32 | One configuration byte per lane |
| run_en | input | 1 | Run command strobe |
| run_xy | input | 128 | Packed x/y operands, 32 bits per lane |
| run_z | input | 64 | Angle operand per lane, used on the first run only |
| out_valid | output | 1 | Result strobe, one cycle after an accepted run |
| out_xy | output | 128 | Packed x/y results |
| out_z | output | 64 | Angle result per lane |

## Verification
The bench drives multi-run sequences in which each result is fed back as the next operand. These sequences catch a unit that takes its angle from `run_z` after the first run: junk on that input would then corrupt the rotation. A mixed configuration puts a circular vector, a linear division and two hyperbolic lanes side by side. A hyperbolic lane that skips the repeated iterations 4 and 13, or starts at index 0, drifts away from the reference from that step onward. Sequences starting at index 29 with negative operands expose a counter that wraps past 31 instead of freezing. A configure issued together with a run shows whether a design wrongly lets the run through.

// File: rtl/cordic_simd_pkg.sv
package cordic_simd_pkg;

  localparam int DW       = 16;          // lane data and angle width
  localparam int IDXW     = 5;           // iteration index width
  localparam int ANG_FRAC = 13;          // fraction bits of the angle format
  localparam logic [IDXW-1:0] IDX_LAST = '1;
  localparam logic [IDXW-1:0] HYP_REP_A = IDXW'(4);
  localparam logic [IDXW-1:0] HYP_REP_B = IDXW'(13);

  typedef enum logic {MODE_ROT = 1'b0, MODE_VEC = 1'b1} cmode_e;

  typedef enum logic [1:0] {
    SYS_CIRC = 2'b00,
    SYS_LIN  = 2'b01,
    SYS_HYP  = 2'b10,
    SYS_RSV  = 2'b11
  } csys_e;

  // Field order matches the configuration byte decoded per lane.
  typedef struct packed {
    cmode_e          mode;
    csys_e           sys;
    logic [IDXW-1:0] idx;
  } ccfg_t;

  // Elementary angle for iteration n; small-n entries are rounded
  // constants, the tail collapses to a plain power of two.
  function automatic logic signed [DW-1:0] elem_angle(csys_e sys, logic [IDXW-1:0] n);
    logic [DW-1:0] pow2;
    pow2 = DW'(1 << ANG_FRAC) >> n;
    case (sys)
      SYS_LIN: return pow2;
      SYS_HYP: begin
        case (n)
          5'd1:    return DW'(4500);
          5'd2:    return DW'(2092);
          5'd3:    return DW'(1029);
          5'd4:    return DW'(513);
          5'd5:    return DW'(256);
          default: return pow2;
        endcase
      end
      default: begin
        case (n)
          5'd0:    return DW'(6434);
          5'd1:    return DW'(3798);
          5'd2:    return DW'(2007);
          5'd3:    return DW'(1019);
          5'd4:    return DW'(511);
          5'd5:    return DW'(256);
          5'd6:    return DW'(128);
          5'd7:    return DW'(64);
          default: return pow2;
        endcase
      end
    endcase
  endfunction

endpackage

// File: rtl/cordic_lane_step.sv
module cordic_lane_step
  import cordic_simd_pkg::*;
(
  input  cmode_e                 mode,
  input  csys_e                  sys,
  input  logic [IDXW-1:0]        n,
  input  logic signed [DW-1:0]   x_i,
  input  logic signed [DW-1:0]   y_i,
  input  logic signed [DW-1:0]   z_i,
  output logic signed [DW-1:0]   x_o,
  output logic signed [DW-1:0]   y_o,
  output logic signed [DW-1:0]   z_o
);

  logic signed [DW-1:0] x_sh, y_sh, e_n;
  logic                 d_pos;

  always_comb begin
    x_sh  = x_i >>> n;
    y_sh  = y_i >>> n;
    e_n   = elem_angle(sys, n);
    d_pos = (mode == MODE_ROT) ? ~z_i[DW-1] : y_i[DW-1];
    if (n == IDX_LAST) begin
      x_o = x_i;
      y_o = y_i;
      z_o = z_i;
    end else begin
      y_o = d_pos ? (y_i + x_sh) : (y_i - x_sh);
      z_o = d_pos ? (z_i - e_n)  : (z_i + e_n);
      case (sys)
        SYS_LIN: x_o = x_i;
        SYS_HYP: x_o = d_pos ? (x_i + y_sh) : (x_i - y_sh);
        default: x_o = d_pos ? (x_i - y_sh) : (x_i + y_sh);
      endcase
    end
  end

endmodule

// File: rtl/cordic_lane_ctl.sv
module cordic_lane_ctl
  import cordic_simd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic                 run_go,
  input  ccfg_t                cfg_byte,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] y_in,
  input  logic signed [DW-1:0] z_in,
  output logic signed [DW-1:0] x_out,
  output logic signed [DW-1:0] y_out,
  output logic signed [DW-1:0] z_out,
  output logic [IDXW-1:0]      idx_out
);

  cmode_e               mode_q, mode_d;
  csys_e                sys_q, sys_d;
  logic [IDXW-1:0]      idx_q, idx_d;
  logic                 rep_q, rep_d;
  logic                 fresh_q, fresh_d;
  logic signed [DW-1:0] z_q, z_d;
  logic signed [DW-1:0] z_src, x_s, y_s, z_s;
  logic                 state_en;

  assign z_src    = fresh_q ? z_in : z_q;
  assign state_en = cfg_load | run_go;
  assign idx_out  = idx_q;

  cordic_lane_step u_step (
    .mode (mode_q),
    .sys  (sys_q),
    .n    (idx_q),
    .x_i  (x_in),
    .y_i  (y_in),
    .z_i  (z_src),
    .x_o  (x_s),
    .y_o  (y_s),
    .z_o  (z_s)
  );

  // Next-state logic
  always_comb begin
    mode_d  = mode_q;
    sys_d   = sys_q;
    idx_d   = idx_q;
    rep_d   = rep_q;
    fresh_d = fresh_q;
    z_d     = z_q;
    if (cfg_load) begin
      mode_d  = cfg_byte.mode;
      sys_d   = cfg_byte.sys;
      idx_d   = (cfg_byte.sys == SYS_HYP && cfg_byte.idx == '0) ? IDXW'(1) : cfg_byte.idx;
      rep_d   = 1'b0;
      fresh_d = 1'b1;
    end else if (run_go) begin
      z_d     = z_s;
      fresh_d = 1'b0;
      if (idx_q != IDX_LAST) begin
        if (sys_q == SYS_HYP && (idx_q == HYP_REP_A || idx_q == HYP_REP_B) && !rep_q) begin
          rep_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          rep_d = 1'b0;
        end
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_ROT;
      sys_q   <= SYS_CIRC;
      idx_q   <= IDX_LAST;
      rep_q   <= 1'b0;
      fresh_q <= 1'b1;
      z_q     <= '0;
    end else if (state_en) begin
      mode_q  <= mode_d;
      sys_q   <= sys_d;
      idx_q   <= idx_d;
      rep_q   <= rep_d;
      fresh_q <= fresh_d;
      z_q     <= z_d;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_out <= '0;
      y_out <= '0;
      z_out <= '0;
    end else if (run_go) begin
      x_out <= x_s;
      y_out <= y_s;
      z_out <= z_s;
    end
  end

endmodule

// File: rtl/cordic_simd_unit.sv
module cordic_simd_unit
  import cordic_simd_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_en,
  input  logic [LANES*8-1:0]     cfg_word,
  input  logic                   run_en,
  input  logic [LANES*2*DW-1:0]  run_xy,
  input  logic [LANES*DW-1:0]    run_z,
  output logic                   out_valid,
  output logic [LANES*2*DW-1:0]  out_xy,
  output logic [LANES*DW-1:0]    out_z
);

  localparam int XYW = 2 * DW;

  logic                        run_go;
  logic [LANES-1:0][IDXW-1:0]  lane_idx;

  // A configure in the same cycle takes precedence over a run.
  assign run_go = run_en & ~cfg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= run_go;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    cordic_lane_ctl u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_load (cfg_en),
      .run_go   (run_go),
      .cfg_byte (ccfg_t'(cfg_word[8*k +: 8])),
      .x_in     (run_xy[XYW*k + DW +: DW]),
      .y_in     (run_xy[XYW*k +: DW]),
      .z_in     (run_z[DW*k +: DW]),
      .x_out    (out_xy[XYW*k + DW +: DW]),
      .y_out    (out_xy[XYW*k +: DW]),
      .z_out    (out_z[DW*k +: DW]),
      .idx_out  (lane_idx[k])
    );
  end

endmodule

// File: rtl/cordic_simd_unit_chk.sv
module cordic_simd_unit_chk
  import cordic_simd_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_en,
  input logic                       run_en,
  input logic [LANES*2*DW-1:0]      run_xy,
  input logic                       out_valid,
  input logic [LANES*2*DW-1:0]      out_xy,
  input logic [LANES-1:0][IDXW-1:0] lane_idx
);

  AST_RUN_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cfg_en) |=> out_valid); // R3

  AST_COLLIDE_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> !out_valid); // R10

  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !out_valid); // R3

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    AST_IDX_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !run_en) |=> $stable(lane_idx[k])); // R7

    AST_IDX_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !cfg_en && lane_idx[k] != '1) |=>
        (lane_idx[k] == $past(lane_idx[k]) + 1'b1 || lane_idx[k] == $past(lane_idx[k]))); // R8

    AST_IDX_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !cfg_en && lane_idx[k] == '1) |=> (lane_idx[k] == '1)); // R9

    AST_SAT_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !cfg_en && lane_idx[k] == '1) |=>
        (out_xy[2*DW*k +: 2*DW] == $past(run_xy[2*DW*k +: 2*DW]))); // R9
  end

endmodule

bind cordic_simd_unit cordic_simd_unit_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .run_en    (run_en),
  .run_xy    (run_xy),
  .out_valid (out_valid),
  .out_xy    (out_xy),
  .lane_idx  (lane_idx)
);

// File: tb/cordic_simd_unit_bench.sv
`timescale 1ns/1ps
module cordic_simd_unit_bench;

  localparam int L = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_en, run_en;
  logic [31:0]  cfg_word;
  logic [127:0] run_xy, out_xy;
  logic [63:0]  run_z, out_z;
  logic         out_valid;

  always #2.5 clk = ~clk;

  cordic_simd_unit u_cordic_simd_unit (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_word(cfg_word),
    .run_en(run_en), .run_xy(run_xy), .run_z(run_z),
    .out_valid(out_valid), .out_xy(out_xy), .out_z(out_z)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Reference state per lane
  int                  m_mode[L], m_sys[L], m_idx[L];
  bit                  m_rep[L], m_fresh[L];
  logic signed [15:0]  m_x[L], m_y[L], m_z[L];
  logic signed [15:0]  seen_y[L], seen_z[L];

  logic [191:0] q_exp[$];
  string        q_tag[$];

  function automatic int ang(int sys, int n);
    if (sys == 1) return 8192 >> n;
    if (sys == 2) begin
      if (n >= 1 && n < 6) return int'($atanh(2.0 ** (-n)) * 8192.0);
      return 8192 >> n;
    end
    if (n < 8) return int'($atan(2.0 ** (-n)) * 8192.0);
    return 8192 >> n;
  endfunction

  task automatic chk(string req, logic [191:0] act, logic [191:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic near(string req, int act, int exp, int tol);
    n_chk++;
    if (act > exp + tol || act < exp - tol) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (+/-%0d)", req, act, exp, tol);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_en = 1'b0;
    run_en = 1'b0;
  endtask

  task automatic apply_cfg(logic [31:0] w, bit with_run);
    logic [7:0] b;
    @(negedge clk);
    cfg_en   = 1'b1;
    cfg_word = w;
    run_en   = with_run;
    run_xy   = {4{32'h1111_2222}};
    run_z    = {4{16'h0333}};
    for (int k = 0; k < L; k++) begin
      b          = w[8*k +: 8];
      m_mode[k]  = int'(b[7]);
      m_sys[k]   = int'(b[6:5]);
      m_idx[k]   = int'(b[4:0]);
      if (m_sys[k] == 2 && m_idx[k] == 0) m_idx[k] = 1;
      m_rep[k]   = 1'b0;
      m_fresh[k] = 1'b1;
    end
  endtask

  // Drive one run command and push the reference result for it.
  task automatic apply_run(logic [127:0] xy, logic [63:0] zz, string tag);
    logic signed [15:0] xi, yi, zi, xo, yo, zo, e, xs, ys;
    logic [191:0] exp;
    bit dp;
    int n, s;
    @(negedge clk);
    cfg_en = 1'b0;
    run_en = 1'b1;
    run_xy = xy;
    run_z  = zz;
    for (int k = 0; k < L; k++) begin
      xi = xy[32*k + 16 +: 16];
      yi = xy[32*k +: 16];
      zi = m_fresh[k] ? zz[16*k +: 16] : m_z[k];
      n  = m_idx[k];
      s  = m_sys[k];
      if (n == 31) begin
        xo = xi; yo = yi; zo = zi;
      end else begin
        e  = 16'(ang(s, n));
        dp = (m_mode[k] == 0) ? (zi >= 0) : (yi < 0);
        xs = xi >>> n;
        ys = yi >>> n;
        yo = dp ? yi + xs : yi - xs;
        zo = dp ? zi - e : zi + e;
        if (s == 1)      xo = xi;
        else if (s == 2) xo = dp ? xi + ys : xi - ys;
        else             xo = dp ? xi - ys : xi + ys;
        if (s == 2 && (n == 4 || n == 13) && !m_rep[k]) m_rep[k] = 1'b1;
        else begin
          m_idx[k] = n + 1;
          m_rep[k] = 1'b0;
        end
      end
      m_x[k] = xo; m_y[k] = yo; m_z[k] = zo; m_fresh[k] = 1'b0;
      exp[64 + 32*k +: 32] = {xo, yo};
      exp[16*k +: 16]      = zo;
    end
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  function automatic logic [127:0] fb_xy();
    logic [127:0] r;
    for (int k = 0; k < L; k++) r[32*k +: 32] = {m_x[k], m_y[k]};
    return r;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops the oldest expected item whenever a result shows up.
  always @(negedge clk) begin
    logic [191:0] e;
    string t;
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (q_exp.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R10: out_valid actual 1 expected 0 (no run pending)");
      end else begin
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(t, {out_xy, out_z}, e);
        for (int k = 0; k < L; k++) begin
          seen_y[k] = out_xy[32*k +: 16];
          seen_z[k] = out_z[16*k +: 16];
        end
      end
    end
  end

  initial begin
    #(5.0 * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int k = 0; k < L; k++) begin
      m_mode[k] = 0; m_sys[k] = 0; m_idx[k] = 31;
      m_rep[k] = 1'b0; m_fresh[k] = 1'b1; m_z[k] = '0;
      m_x[k] = '0; m_y[k] = '0;
    end
    rst_n = 1'b0; cfg_en = 1'b0; run_en = 1'b0;
    cfg_word = '0; run_xy = '0; run_z = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 192'(out_valid), 192'(0));
    chk("R1", 192'(out_xy), 192'(0));
    chk("R1", 192'(out_z), 192'(0));

    // Unconfigured lanes pass operands through (R1, R9)
    apply_run({4{16'h1234, 16'hFEDC}}, {4{16'h0777}}, "R1/R9");
    idle();

    // Circular rotation, junk angle input after the first run (R3, R5, R6)
    apply_cfg(32'h0000_0000, 1'b0);
    for (int i = 0; i < 16; i++) begin
      if (i == 0)
        apply_run({4{16'sd4096, 16'sd0}},
                  {16'sd0, 16'sd8000, -16'sd3000, 16'sd6434}, "R3");
      else
        apply_run(fb_xy(), {4{16'h5A5A}}, "R5/R6");
    end
    idle(); idle();
    for (int k = 0; k < L; k++) near("R4", int'(seen_z[k]), 0, 16);

    // Mixed lanes: circular vec, linear vec, hyperbolic rot from 0, hyperbolic vec (R7, R8)
    apply_cfg({8'hC1, 8'h40, 8'hA0, 8'h80}, 1'b0);
    for (int i = 0; i < 18; i++) begin
      if (i == 0)
        apply_run({16'sd6000, 16'sd2000, 16'sd4096, 16'sd0,
                   16'sd4096, 16'sd1024, 16'sd3000, 16'sd2000},
                  {16'sd0, 16'sd2000, 16'sd0, 16'sd0}, "R7/R8");
      else
        apply_run(fb_xy(), {4{16'h7E7E}}, "R7/R8");
    end
    idle(); idle();
    near("R11", int'(seen_z[1]), 2048, 8);
    near("R4", int'(seen_y[0]), 0, 16);
    near("R4", int'(seen_y[3]), 0, 16);

    // Index 29 up to saturation; lane 3 uses system code 11 (R2, R9)
    apply_cfg(32'h7D1D_1D1D, 1'b0);
    for (int i = 0; i < 4; i++) begin
      if (i == 0)
        apply_run({4{16'shC000, 16'shE000}}, {4{16'h0100}}, "R2/R9");
      else
        apply_run(fb_xy(), {4{16'h0100}}, "R2/R9");
    end
    idle(); idle();

    // Configure colliding with a run (R10)
    apply_cfg(32'h0202_0202, 1'b1);
    idle();
    chk("R10", 192'(out_valid), 192'(0));
    apply_run({4{16'sd3000, 16'sd1000}}, {4{16'sd1500}}, "R10");
    idle(); idle();

    n_chk++;
    if (q_exp.size() != 0) begin
      n_bad++;
      $display("FAIL R3: pending results actual %0d expected 0", q_exp.size());
    end
    summary();
  end

endmodule